// File: doc/BRIEF.md
# Programmable-Edge Synchronous Serial Master

This block is a serial master that talks to simple external devices over three kinds of wire: a serial clock, a single data line that carries bits in both directions, and two active-low chip enables. Software programs a control word that picks the clock divider, the clock edge that shifts data out, the chip enable to use and two bit counts. One count is for the bits written, and one is for the bits read back afterwards. A write to the status location then starts the transfer. While the transfer runs, the status word reports busy. When the final bit has been latched, the status word reports done.

Each bit takes one full serial clock period. The period has two halves, and each half lasts a power-of-two number of system clocks. The first edge of a bit is the shift edge, where the master drives the next output bit or releases the line. The second edge is the latch edge, where the receiver samples. All configuration is frozen while a transfer runs, so the timing of every bit is the same from the first bit to the last.

Top module: `ssm_master`

## Requirements
- R1: The half period of the serial clock is 2^c system clocks for a divider code c of 3 to 7, which gives a full period of /16 to /256. Codes 0 to 2 behave as code 3. The divider code sits in control bits [2:0].
- R2: When no transfer is running, the serial clock rests at 1 if control bit 3 is 0 (shift on the falling edge, latch on the rising edge). It rests at 0 if control bit 3 is 1 (shift on the rising edge, latch on the falling edge). The first edge of each bit is the shift edge, and the clock ends the transfer at its resting level.
- R3: Control bit 4 selects one chip enable: 0 picks ce_n[0] and 1 picks ce_n[1]. That chip enable goes low in the cycle after the start write and stays low until the final latch edge. The other chip enable stays high. The first shift edge comes one half period after the chip enable goes low.
- R4: Control bits [8:5] hold the written bit count minus one, so 1 to 16 bits are written. Those bits are the low bits of the transmit register (address 1), sent starting from the highest of them. Each bit is driven with sd_oe high from its shift edge and is held steady through its latch edge.
- R5: After the written bits, the master reads the number of bits given in control bits [13:9]. Values above 16 count as 16. During these bits sd_oe is low, and sd_i is sampled at each latch edge. Each sampled bit enters the receive register (address 2) at bit 0 and moves the older bits up. The receive register is cleared when a transfer starts.
- R6: Shift edges and latch edges alternate, one every half period. A transfer of N written plus read bits has exactly 2N edges.
- R7: Status (address 3) bit 0 is busy and bit 1 is done. Busy is set from the cycle after the start write until the final latch edge. Done is set at the final latch edge and cleared by the next start.
- R8: While busy, writes to any address are ignored: the control and transmit registers keep their values, and a second start is not taken.
- R9: After reset the registers read 0, the serial clock is 1, both chip enables are high and sd_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads (0 control, 1 transmit, 2 receive, 3 status/start) |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data for reg_addr |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data output value |
| sd_oe | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data input value |
| ce_n | output | 2 | Active-low chip enables |

## Verification
The hardest case to reach is a register write that arrives in the middle of a running transfer. Such a write must change neither the clock nor the bits nor the stored configuration, and a second start must not be taken. The bench drives a control write, a transmit write and a start write in the system-clock cycles between two serial clock edges of a live transfer. It then checks the edge count, the register values read back and a quiet interval after the transfer. Two other cases sit at the edge of the configuration and are swept on purpose: read counts above 16 and the low divider codes, which behave as /16.

// File: rtl/ssm_pkg.sv
// Shared definitions for the serial master: register address map and the
// rule that turns a divider code into a half-period exponent.
package ssm_pkg;

    // Register locations seen on the write/read port.
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TXD  = 2'd1,
        REG_RXD  = 2'd2,
        REG_STAT = 2'd3
    } ssm_reg_e;

    // Half-period exponent for a divider code; codes below the minimum clamp up.
    function automatic int half_exp(input int code, input int min_code);
        return (code < min_code) ? min_code : code;
    endfunction

endpackage

// File: rtl/ssm_regs.sv
// Register file of the serial master.
// Holds the control word and the transmit word, presents the read mux and
// generates a one-cycle start pulse. Assumes the engine reports busy for the
// whole transfer; all writes are dropped while busy, so configuration stays
// frozen during a transfer.
module ssm_regs
    import ssm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 3,
    parameter int LEN_W  = 4,
    parameter int CE_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              start,
    output logic [CODE_W-1:0] div_code,
    output logic              shift_rise,
    output logic [CE_W-1:0]   ce_sel,
    output logic [LEN_W-1:0]  tx_len_m1,
    output logic [LEN_W:0]    rx_len,
    output logic [DATA_W-1:0] tx_word
);

    localparam int EDGE_POS = CODE_W;
    localparam int CESL_POS = CODE_W + 1;
    localparam int TXL_POS  = CESL_POS + CE_W;
    localparam int RXL_POS  = TXL_POS + LEN_W;
    localparam int CTRL_W   = RXL_POS + LEN_W + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] txd_q;
    logic              wr_ok;
    ssm_reg_e          sel;

    assign sel   = ssm_reg_e'(reg_addr);
    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (sel == REG_STAT);

    // Store control and transmit words on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            txd_q  <= '0;
        end else if (wr_ok) begin
            case (sel)
                REG_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                REG_TXD:  txd_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    assign div_code   = ctrl_q[CODE_W-1:0];
    assign shift_rise = ctrl_q[EDGE_POS];
    assign ce_sel     = ctrl_q[CESL_POS +: CE_W];
    assign tx_len_m1  = ctrl_q[TXL_POS +: LEN_W];
    assign rx_len     = ctrl_q[RXL_POS +: LEN_W + 1];
    assign tx_word    = txd_q;

    // Read mux for the addressed register.
    always_comb begin
        rd_data = '0;
        case (sel)
            REG_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
            REG_TXD:  rd_data = txd_q;
            REG_RXD:  rd_data = rx_word;
            REG_STAT: rd_data[1:0] = {done, busy};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ssm_clkdiv.sv
// Half-period tick generator.
// A free-running counter is cleared at the start of a transfer. A tick is
// produced whenever the low bits selected by the divider code are all ones,
// which gives one tick every 2^exp cycles. Assumes the code is stable while
// run is high.
module ssm_clkdiv
    import ssm_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int MIN_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    localparam int NCODE = 1 << CODE_W;
    localparam int CNT_W = NCODE - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [NCODE-1:0] hit;

    // One terminal-count detector per divider code.
    for (genvar c = 0; c < NCODE; c++) begin : g_hit
        localparam int EXP = half_exp(c, MIN_CODE);
        assign hit[c] = &cnt_q[EXP-1:0];
    end

    assign tick = run && hit[code];

    // Count system clocks during a transfer; restart aligns the first tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ssm_engine.sv
// Transfer sequencer and data paths.
// Counts serial clock edges. Even edges are shift edges and odd edges are
// latch edges. Written bits come out first, starting from the highest of
// them; read bits follow with the line released. Assumes the configuration
// inputs are held steady while busy and that sd_i is synchronous to clk.
module ssm_engine #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int CE_W   = 1,
    parameter int NUM_CE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              shift_rise,
    input  logic [CE_W-1:0]   ce_sel,
    input  logic [LEN_W-1:0]  tx_len_m1,
    input  logic [LEN_W:0]    rx_len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sd_i,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sd_o,
    output logic              sd_oe,
    output logic [NUM_CE-1:0] ce_n,
    output logic [DATA_W-1:0] rx_word
);

    localparam int EDGE_W = $clog2(4 * DATA_W);
    localparam int TOT_W  = EDGE_W + 1;
    localparam logic [LEN_W:0] RX_MAX = (LEN_W + 1)'(DATA_W);

    logic [EDGE_W-1:0] edge_q;
    logic [DATA_W-1:0] txsh_q;
    logic [DATA_W-1:0] rxsh_q;
    logic              busy_q;
    logic              done_q;
    logic              sclk_q;
    logic              sdo_q;
    logic              oe_q;

    logic [LEN_W:0]    rx_eff;
    logic [TOT_W-1:0]  tot_edges;
    logic [EDGE_W-1:0] bit_idx;
    logic              in_tx;
    logic              last_edge;
    logic              shift_edge;
    logic              idle_lvl;
    logic [LEN_W-1:0]  pad;

    assign rx_eff     = (rx_len > RX_MAX) ? RX_MAX : rx_len;
    assign tot_edges  = (TOT_W'(tx_len_m1) + TOT_W'(1) + TOT_W'(rx_eff)) << 1;
    assign bit_idx    = edge_q >> 1;
    assign in_tx      = bit_idx <= EDGE_W'(tx_len_m1);
    assign last_edge  = ({1'b0, edge_q} == (tot_edges - TOT_W'(1)));
    assign shift_edge = !edge_q[0];
    assign idle_lvl   = !shift_rise;
    assign pad        = LEN_W'(DATA_W - 1) - tx_len_m1;

    // Sequence busy, done, edge count and the serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            edge_q <= '0;
            sclk_q <= 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            edge_q <= '0;
            sclk_q <= idle_lvl;
        end else if (busy_q) begin
            if (tick) begin
                sclk_q <= !sclk_q;
                if (last_edge) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    edge_q <= edge_q + EDGE_W'(1);
                end
            end
        end else begin
            sclk_q <= idle_lvl;
        end
    end

    // Transmit path: load left-aligned, drive or release at shift edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txsh_q <= '0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (start) begin
            txsh_q <= tx_word << pad;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (busy_q && tick) begin
            if (last_edge) begin
                sdo_q <= 1'b0;
                oe_q  <= 1'b0;
            end else if (shift_edge) begin
                if (in_tx) begin
                    sdo_q  <= txsh_q[DATA_W-1];
                    oe_q   <= 1'b1;
                    txsh_q <= txsh_q << 1;
                end else begin
                    sdo_q <= 1'b0;
                    oe_q  <= 1'b0;
                end
            end
        end
    end

    // Receive path: sample the line at latch edges of read bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxsh_q <= '0;
        end else if (start) begin
            rxsh_q <= '0;
        end else if (busy_q && tick && !shift_edge && !in_tx) begin
            rxsh_q <= {rxsh_q[DATA_W-2:0], sd_i};
        end
    end

    // One active-low enable per device, low only for the selected one.
    for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
        assign ce_n[i] = !(busy_q && (ce_sel == CE_W'(i)));
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sclk    = sclk_q;
    assign sd_o    = sdo_q;
    assign sd_oe   = oe_q;
    assign rx_word = rxsh_q;

endmodule

// File: rtl/ssm_master.sv
// Top of the programmable-edge synchronous serial master.
// Connects the register file, the half-period tick generator and the
// transfer engine. Assumes a single clock domain; the external data line
// is built from sd_o and sd_oe outside this block.
module ssm_master #(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 3,
    parameter int MIN_CODE = 3,
    parameter int NUM_CE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk_o,
    output logic              sd_o,
    output logic              sd_oe,
    input  logic              sd_i,
    output logic [NUM_CE-1:0] ce_n
);

    localparam int LEN_W = $clog2(DATA_W);
    localparam int CE_W  = (NUM_CE > 1) ? $clog2(NUM_CE) : 1;

    logic              busy_w;
    logic              done_w;
    logic              tick_w;
    logic              start_w;
    logic              idle_w;
    logic [CODE_W-1:0] code_w;
    logic              shift_rise_w;
    logic [CE_W-1:0]   ce_sel_w;
    logic [LEN_W-1:0]  tx_len_m1_w;
    logic [LEN_W:0]    rx_len_w;
    logic [DATA_W-1:0] tx_word_w;
    logic [DATA_W-1:0] rx_word_w;

    assign idle_w = !shift_rise_w;

    ssm_regs #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .LEN_W(LEN_W), .CE_W(CE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy_w), .done(done_w),
        .rx_word(rx_word_w), .start(start_w), .div_code(code_w),
        .shift_rise(shift_rise_w), .ce_sel(ce_sel_w), .tx_len_m1(tx_len_m1_w),
        .rx_len(rx_len_w), .tx_word(tx_word_w)
    );

    ssm_clkdiv #(
        .CODE_W(CODE_W), .MIN_CODE(MIN_CODE)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .restart(start_w), .run(busy_w),
        .code(code_w), .tick(tick_w)
    );

    ssm_engine #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .CE_W(CE_W), .NUM_CE(NUM_CE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start_w), .tick(tick_w),
        .shift_rise(shift_rise_w), .ce_sel(ce_sel_w), .tx_len_m1(tx_len_m1_w),
        .rx_len(rx_len_w), .tx_word(tx_word_w), .sd_i(sd_i), .busy(busy_w),
        .done(done_w), .sclk(sclk_o), .sd_o(sd_o), .sd_oe(sd_oe),
        .ce_n(ce_n), .rx_word(rx_word_w)
    );

endmodule

// File: rtl/ssm_master_chk.sv
// Property checker for the serial master, bound to the top module.
// Observes ports plus the busy/done/tick/idle-level nets of the top.
module ssm_master_chk #(
    parameter int NUM_CE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              sd_o,
    input logic              sd_oe,
    input logic [NUM_CE-1:0] ce_n,
    input logic              busy,
    input logic              done,
    input logic              tick,
    input logic              idle_lvl
);

    p_ce_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~ce_n) == 1));

    p_ce_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ce_n));

    p_oe_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> busy);

    p_edge_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sclk != $past(sclk))) |-> $past(tick));

    p_rest_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (sclk == $past(idle_lvl)));

    p_hold_at_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sd_oe && $past(sd_oe) && (sclk == idle_lvl) && ($past(sclk) != idle_lvl))
        |-> $stable(sd_o));

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

endmodule

bind ssm_master ssm_master_chk #(.NUM_CE(NUM_CE)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_o), .sd_o(sd_o), .sd_oe(sd_oe),
    .ce_n(ce_n), .busy(busy_w), .done(done_w), .tick(tick_w), .idle_lvl(idle_w)
);

// File: tb/test_ssm_master.sv
module test_ssm_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  reg_addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        sclk_o;
    logic        sd_o;
    logic        sd_oe;
    logic        sd_i;
    logic [1:0]  ce_n;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    ssm_master i_ssm_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .sclk_o(sclk_o), .sd_o(sd_o),
        .sd_oe(sd_oe), .sd_i(sd_i), .ce_n(ce_n)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog expired actual=%0d expected<190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [15:0] lowmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
    endfunction

    // One transfer with a slave model; optional writes poked mid-transfer.
    task automatic run_xfer(input int code, input int sr, input int ces, input int txl,
                            input int rxl, input logic [15:0] txw, input logic [15:0] rxp,
                            input bit poke);
        logic [15:0] ctrl, rdv, txcap;
        logic [1:0]  ce_exp;
        logic        idle, prev_s, prev_d, prev_oe;
        int          h, rxe, n, edges, rxidx;
        bit          t_ok, dir_ok, oe_ok, ce_ok;
        ctrl = 16'(code) | 16'(sr << 3) | 16'(ces << 4) | 16'((txl - 1) << 5) | 16'(rxl << 9);
        wr(2'd0, ctrl);
        wr(2'd1, txw);
        idle = (sr == 0);
        chk(sclk_o === idle, "R2 resting level before start", sclk_o, idle);
        h   = 1 << ((code < 3) ? 3 : code);
        rxe = (rxl > 16) ? 16 : rxl;
        n   = txl + rxe;
        ce_exp = (ces != 0) ? 2'b01 : 2'b10;
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 2'd3; wr_data = 16'h0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data[1:0] === 2'b01, "R7 busy set and done cleared after start", rd_data[1:0], 2'b01);
        chk(ce_n === ce_exp, "R3 chip enable after start", ce_n, ce_exp);
        prev_s = sclk_o; prev_d = sd_o; prev_oe = sd_oe;
        edges = 0; rxidx = 0; txcap = 16'h0;
        t_ok = 1; dir_ok = 1; oe_ok = 1; ce_ok = 1;
        for (int k = 1; k <= 2 * n * h; k++) begin
            @(negedge clk);
            if (poke) begin
                case (k)
                    3: begin wr_en = 1'b1; reg_addr = 2'd0; wr_data = ~ctrl & 16'h3FFF; end
                    4: begin reg_addr = 2'd1; wr_data = ~txw; end
                    5: begin reg_addr = 2'd3; end
                    6: begin wr_en = 1'b0; reg_addr = 2'd3; end
                    default: ;
                endcase
            end
            if (sclk_o !== prev_s) begin
                edges++;
                if (k != edges * h) t_ok = 0;
                if ((edges % 2) == 1) begin
                    if (sclk_o !== ~idle) dir_ok = 0;
                    if ((edges + 1) / 2 > txl) begin
                        sd_i = rxp[rxe - 1 - rxidx];
                        rxidx++;
                        if (sd_oe !== 1'b0) oe_ok = 0;
                    end else if (sd_oe !== 1'b1) begin
                        oe_ok = 0;
                    end
                end else begin
                    if (sclk_o !== idle) dir_ok = 0;
                    if (edges / 2 <= txl) begin
                        txcap = {txcap[14:0], prev_d};
                        if (prev_oe !== 1'b1) oe_ok = 0;
                    end
                end
            end
            if (k < 2 * n * h && ce_n !== ce_exp) ce_ok = 0;
            prev_s = sclk_o; prev_d = sd_o; prev_oe = sd_oe;
        end
        chk(t_ok, "R1 edges fall on multiples of the half period", code, h);
        chk(edges == 2 * n, "R6 edge count", edges, 2 * n);
        chk(dir_ok, "R2 shift edge leaves resting level", sr, idle);
        chk(oe_ok, "R5 output enable high for written bits, low for read bits", txl, rxe);
        chk(ce_ok, "R3 chip enable held for the whole transfer", ces, ce_exp);
        chk(txcap === (txw & lowmask(txl)), "R4 written bits", txcap, txw & lowmask(txl));
        chk(rd_data[1:0] === 2'b10, "R7 done set and busy cleared at final latch edge", rd_data[1:0], 2'b10);
        chk(ce_n === 2'b11, "R3 chip enables released at end", ce_n, 2'b11);
        chk(sd_oe === 1'b0 && sclk_o === idle, "R2 clock back at rest with line released",
            {sd_oe, sclk_o}, {1'b0, idle});
        rd(2'd2, rdv);
        chk(rdv === (rxp & lowmask(rxe)), "R5 received word", rdv, rxp & lowmask(rxe));
        if (poke) begin
            rd(2'd0, rdv);
            chk(rdv === ctrl, "R8 control unchanged by write during transfer", rdv, ctrl);
            rd(2'd1, rdv);
            chk(rdv === txw, "R8 transmit word unchanged by write during transfer", rdv, txw);
            reg_addr = 2'd3;
            repeat (2 * h) @(negedge clk);
            chk(rd_data[1:0] === 2'b10 && sclk_o === idle, "R8 start during transfer not taken",
                rd_data[1:0], 2'b10);
        end
    endtask

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; wr_en = 1'b0; reg_addr = 2'd0; wr_data = 16'h0; sd_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(sclk_o === 1'b1 && ce_n === 2'b11 && sd_oe === 1'b0, "R9 outputs in reset",
            {sclk_o, ce_n, sd_oe}, 4'b1110);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v === 16'h0, "R9 register reads zero after reset", v, 0);
        end
        // R1 R2 R3: every divider code with both edge choices.
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                run_xfer(c, s, c % 2, 3, 2, 16'(16'h0005 + c), 16'(16'h0002 ^ s), 1'b0);
            end
        end
        // R4: every written length, write only.
        for (int t = 1; t <= 16; t++) begin
            run_xfer(3, t % 2, (t / 2) % 2, t, 0, 16'(16'hA5C3 * t + 16'h1357), 16'h0, 1'b0);
        end
        // R5: every read length including counts above the maximum.
        for (int r = 0; r <= 17; r++) begin
            run_xfer(3 + (r % 2), (r / 2) % 2, r % 2, (r % 4) + 1, r,
                     16'(16'h9E37 + r), 16'(16'h3C96 ^ (r * 16'h0F1D)), 1'b0);
        end
        // R8: writes and a start attempt while busy.
        run_xfer(4, 1, 1, 5, 4, 16'h0016, 16'h000B, 1'b1);
        run_xfer(3, 0, 0, 16, 16, 16'hC0DE, 16'h5AA5, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule